// File: doc/BRIEF.md
# NAND Flash Command Sequence Decoder

This block is the command front end on the device side of a small-page NAND flash memory. It watches the shared I/O bus and its strobes: an active-low write enable, a command latch enable and an address latch enable. It accepts a byte only on a command cycle. A command cycle is a rising edge of write enable while command latch enable is high and address latch enable is low. The block follows one-, two- and three-cycle command sequences and reports each operation that must start. It gives a one-cycle start pulse together with an operation code. The operations are: read with an area pointer, signature read, status read, page program, copy-back program, block erase and reset.

Sequences that are only partly entered are held in a small tracker. Address and data cycles that fall between command cycles leave the tracker alone. Address cycles are reported only as a one-cycle flag. While the array reports busy, the block accepts just the status read and the reset. Every other byte is dropped and changes nothing. Undefined codes and confirm codes that arrive out of order start nothing and return the tracker to idle.

Top module: `nfc_cmd_interp`

## Requirements
- R1: A byte is decoded only on a command cycle: the first clock on which we_n is sampled high after it was sampled low, with cle high and ale low. Any resulting pulse appears on op_start one clock after that cycle and lasts one clock. While op_start is low, op_code is 0. After reset, op_start is low and read_area is 0.
- R2: Codes 00h, 01h and 50h each give op_code 1 (read) and set read_area to 0, 1 and 2 respectively. The area holds until the next accepted area change.
- R3: Code 90h gives op_code 2 (signature read). Code 70h gives op_code 3 (status read).
- R4: 80h followed by confirm 10h gives op_code 4 (page program) on the confirm. 80h by itself starts nothing.
- R5: 00h, then 8Ah, then 10h gives op_code 6 (copy-back program) on the 10h. The 00h still gives its read pulse.
- R6: 60h followed by confirm D0h gives op_code 5 (block erase).
- R7: FFh gives op_code 7 (reset) from any state, including while busy. It discards any partly entered sequence and sets read_area to 0.
- R8: While busy is high, only 70h and FFh are accepted. Any other command byte gives no pulse and leaves read_area and the sequence state unchanged.
- R9: An undefined code, or a confirm code (10h, D0h, 8Ah) arriving out of order, gives no pulse and returns the tracker to idle.
- R10: Address cycles (ale high, cle low) and data cycles (cle low) do not change the sequence state. Each address cycle gives a one-clock addr_pulse, one clock later.
- R11: A status read (70h) entered in the middle of a sequence does not disturb it. A following confirm still completes the sequence.
- R12: A first-cycle code arriving in the middle of a sequence restarts decoding from that code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples all bus signals |
| rst_n | input | 1 | Active-low synchronous reset |
| io_bus | input | IO_W (8) | I/O bus; commands are taken from the low byte |
| we_n | input | 1 | Active-low write enable; a byte is taken on its rising edge |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| busy | input | 1 | Array operation in progress |
| op_start | output | 1 | One-clock pulse: start the operation on op_code |
| op_code | output | 3 | Operation: 1 read, 2 signature, 3 status, 4 program, 5 erase, 6 copy-back, 7 reset, 0 none |
| read_area | output | 2 | Read pointer area: 0 A, 1 B, 2 C |
| addr_pulse | output | 1 | One-clock flag for each address cycle |

## Verification
The embedded properties check several rules on every clock. A start pulse must follow a command cycle. op_code must be zero when there is no pulse. While busy, only status or reset may start. Program, erase and copy-back must each come out of their matching pending state. A reset must leave area A and an idle tracker. An address cycle must never move the tracker. The bench's reference model compares every output on every clock. Only its scenarios can show the things a single-cycle property cannot: a dropped byte while busy preserves a half-entered program, a status read interleaved mid-sequence still lets the confirm complete, a restart code redirects the sequence, and an undefined byte prevents a later stray confirm from firing.

// File: rtl/nfc_cmd_pkg.sv
package nfc_cmd_pkg;

    localparam logic [7:0] CODE_RD_A    = 8'h00;
    localparam logic [7:0] CODE_RD_B    = 8'h01;
    localparam logic [7:0] CODE_RD_C    = 8'h50;
    localparam logic [7:0] CODE_SIG     = 8'h90;
    localparam logic [7:0] CODE_STATUS  = 8'h70;
    localparam logic [7:0] CODE_PROG    = 8'h80;
    localparam logic [7:0] CODE_CONF_PG = 8'h10;
    localparam logic [7:0] CODE_CPY_MID = 8'h8A;
    localparam logic [7:0] CODE_ERASE   = 8'h60;
    localparam logic [7:0] CODE_CONF_ER = 8'hD0;
    localparam logic [7:0] CODE_RESET   = 8'hFF;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_READ      = 3'd1,
        OP_SIGNATURE = 3'd2,
        OP_STATUS    = 3'd3,
        OP_PROGRAM   = 3'd4,
        OP_ERASE     = 3'd5,
        OP_COPYBACK  = 3'd6,
        OP_RESET     = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_PROG  = 3'd1,
        SEQ_ERASE = 3'd2,
        SEQ_RDA   = 3'd3,
        SEQ_CPY   = 3'd4
    } seq_e;

    typedef enum logic [1:0] {
        AREA_A = 2'd0,
        AREA_B = 2'd1,
        AREA_C = 2'd2
    } area_e;

    typedef enum logic [3:0] {
        K_RD_A, K_RD_B, K_RD_C, K_SIG, K_STATUS, K_PROG,
        K_CONF_PG, K_CPY_MID, K_ERASE, K_CONF_ER, K_RESET, K_UNDEF
    } kind_e;

    typedef struct packed {
        seq_e  seq;
        area_e area;
        logic  start;
        op_e   op;
        logic  addr;
    } ctl_t;

endpackage

// File: rtl/nfc_we_edge.sv
module nfc_we_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    input  logic cle,
    input  logic ale,
    output logic cmd_cycle,
    output logic addr_cycle
);
    logic we_n_q;
    logic rise;

    always_ff @(posedge clk) begin
        if (!rst_n) we_n_q <= 1'b1;
        else        we_n_q <= we_n;
    end

    assign rise       = we_n & ~we_n_q;
    assign cmd_cycle  = rise & cle & ~ale;
    assign addr_cycle = rise & ale & ~cle;
endmodule

// File: rtl/nfc_code_classify.sv
module nfc_code_classify
    import nfc_cmd_pkg::*;
(
    input  logic [7:0] code,
    output kind_e      kind
);
    always_comb begin
        unique case (code)
            CODE_RD_A:    kind = K_RD_A;
            CODE_RD_B:    kind = K_RD_B;
            CODE_RD_C:    kind = K_RD_C;
            CODE_SIG:     kind = K_SIG;
            CODE_STATUS:  kind = K_STATUS;
            CODE_PROG:    kind = K_PROG;
            CODE_CONF_PG: kind = K_CONF_PG;
            CODE_CPY_MID: kind = K_CPY_MID;
            CODE_ERASE:   kind = K_ERASE;
            CODE_CONF_ER: kind = K_CONF_ER;
            CODE_RESET:   kind = K_RESET;
            default:      kind = K_UNDEF;
        endcase
    end
endmodule

// File: rtl/nfc_cmd_interp.sv
module nfc_cmd_interp
    import nfc_cmd_pkg::*;
#(
    parameter int IO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IO_W-1:0] io_bus,
    input  logic            we_n,
    input  logic            cle,
    input  logic            ale,
    input  logic            busy,
    output logic            op_start,
    output logic [2:0]      op_code,
    output logic [1:0]      read_area,
    output logic            addr_pulse
);
    localparam int CODE_W = 8;

    logic  cmd_cycle;
    logic  addr_cycle;
    kind_e kind;
    ctl_t  s_d, s_q;

    nfc_we_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_n      (we_n),
        .cle       (cle),
        .ale       (ale),
        .cmd_cycle (cmd_cycle),
        .addr_cycle(addr_cycle)
    );

    nfc_code_classify u_cls (
        .code(io_bus[CODE_W-1:0]),
        .kind(kind)
    );

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.op    = OP_NONE;
        s_d.addr  = addr_cycle;
        if (cmd_cycle) begin
            if (busy) begin
                if (kind == K_STATUS) begin
                    s_d.start = 1'b1;
                    s_d.op    = OP_STATUS;
                end else if (kind == K_RESET) begin
                    s_d.start = 1'b1;
                    s_d.op    = OP_RESET;
                    s_d.seq   = SEQ_IDLE;
                    s_d.area  = AREA_A;
                end
            end else begin
                s_d.seq = SEQ_IDLE;
                case (kind)
                    K_RESET: begin
                        s_d.start = 1'b1;
                        s_d.op    = OP_RESET;
                        s_d.area  = AREA_A;
                    end
                    K_STATUS: begin
                        s_d.start = 1'b1;
                        s_d.op    = OP_STATUS;
                        s_d.seq   = s_q.seq;
                    end
                    K_RD_A: begin
                        s_d.start = 1'b1;
                        s_d.op    = OP_READ;
                        s_d.area  = AREA_A;
                        s_d.seq   = SEQ_RDA;
                    end
                    K_RD_B: begin
                        s_d.start = 1'b1;
                        s_d.op    = OP_READ;
                        s_d.area  = AREA_B;
                    end
                    K_RD_C: begin
                        s_d.start = 1'b1;
                        s_d.op    = OP_READ;
                        s_d.area  = AREA_C;
                    end
                    K_SIG: begin
                        s_d.start = 1'b1;
                        s_d.op    = OP_SIGNATURE;
                    end
                    K_PROG:  s_d.seq = SEQ_PROG;
                    K_ERASE: s_d.seq = SEQ_ERASE;
                    K_CPY_MID: begin
                        if (s_q.seq == SEQ_RDA) s_d.seq = SEQ_CPY;
                    end
                    K_CONF_PG: begin
                        if (s_q.seq == SEQ_PROG) begin
                            s_d.start = 1'b1;
                            s_d.op    = OP_PROGRAM;
                        end else if (s_q.seq == SEQ_CPY) begin
                            s_d.start = 1'b1;
                            s_d.op    = OP_COPYBACK;
                        end
                    end
                    K_CONF_ER: begin
                        if (s_q.seq == SEQ_ERASE) begin
                            s_d.start = 1'b1;
                            s_d.op    = OP_ERASE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.seq   <= SEQ_IDLE;
            s_q.area  <= AREA_A;
            s_q.start <= 1'b0;
            s_q.op    <= OP_NONE;
            s_q.addr  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign op_start   = s_q.start;
    assign op_code    = s_q.op;
    assign read_area  = s_q.area;
    assign addr_pulse = s_q.addr;

    AST_START_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(cmd_cycle)); // R1
    AST_QUIET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_start |-> op_code == OP_NONE); // R1
    AST_BUSY_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && $past(busy)) |-> (op_code == OP_STATUS || op_code == OP_RESET)); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_code == OP_RESET) |-> (read_area == AREA_A && s_q.seq == SEQ_IDLE)); // R7
    AST_PROG_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_code == OP_PROGRAM) |-> $past(s_q.seq) == SEQ_PROG); // R4
    AST_CPY_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_code == OP_COPYBACK) |-> $past(s_q.seq) == SEQ_CPY); // R5
    AST_ERASE_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_code == OP_ERASE) |-> $past(s_q.seq) == SEQ_ERASE); // R6
    AST_ADDR_HOLDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr_cycle) |-> s_q.seq == $past(s_q.seq)); // R10
endmodule

// File: tb/nfc_cmd_interp_tb.sv
`timescale 1ns/1ps
module nfc_cmd_interp_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io = 8'h00;
    logic       we_n = 1'b1;
    logic       cle = 1'b0;
    logic       ale = 1'b0;
    logic       busy = 1'b0;
    logic       op_start;
    logic [2:0] op_code;
    logic [1:0] read_area;
    logic       addr_pulse;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    nfc_cmd_interp #(.IO_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_bus(io), .we_n(we_n), .cle(cle),
        .ale(ale), .busy(busy), .op_start(op_start), .op_code(op_code),
        .read_area(read_area), .addr_pulse(addr_pulse)
    );

    // Reference model: mstate 0 idle, 1 after 80h, 2 after 60h, 3 after 00h, 4 after 00h 8Ah
    int m_state = 0;
    int m_area = 0;
    int e_start = 0;
    int e_code = 0;
    int e_addr = 0;
    bit prev_we = 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_area = 0; e_start = 0; e_code = 0; e_addr = 0; prev_we = 1'b1;
        end else begin
            bit stb;
            int nxt;
            stb = we_n && !prev_we;
            prev_we = we_n;
            e_start = 0; e_code = 0;
            e_addr = (stb && ale && !cle) ? 1 : 0;
            if (stb && cle && !ale) begin
                if (busy) begin
                    if (io == 8'h70) begin e_start = 1; e_code = 3; end
                    if (io == 8'hFF) begin e_start = 1; e_code = 7; m_state = 0; m_area = 0; end
                end else begin
                    nxt = 0;
                    case (io)
                        8'hFF: begin e_start = 1; e_code = 7; m_area = 0; end
                        8'h70: begin e_start = 1; e_code = 3; nxt = m_state; end
                        8'h00: begin e_start = 1; e_code = 1; m_area = 0; nxt = 3; end
                        8'h01: begin e_start = 1; e_code = 1; m_area = 1; end
                        8'h50: begin e_start = 1; e_code = 1; m_area = 2; end
                        8'h90: begin e_start = 1; e_code = 2; end
                        8'h80: nxt = 1;
                        8'h60: nxt = 2;
                        8'h8A: if (m_state == 3) nxt = 4;
                        8'h10: begin
                            if (m_state == 1) begin e_start = 1; e_code = 4; end
                            if (m_state == 4) begin e_start = 1; e_code = 6; end
                        end
                        8'hD0: if (m_state == 2) begin e_start = 1; e_code = 5; end
                        default: ;
                    endcase
                    m_state = nxt;
                end
            end
        end
    end

    int last_op = -1;
    always @(negedge clk) begin
        if (op_start) last_op = op_code;
        if (!done) begin
            checks++;
            if (op_start !== e_start[0] || op_code !== e_code[2:0] ||
                read_area !== m_area[1:0] || addr_pulse !== e_addr[0]) begin
                failures++;
                $display("FAIL %s: start/code/area/addr actual %0b/%0d/%0d/%0b expected %0d/%0d/%0d/%0d",
                         cur_req, op_start, op_code, read_area, addr_pulse,
                         e_start, e_code, m_area, e_addr);
            end
        end
    end

    task automatic bus_cycle(input logic [7:0] b, input logic c, input logic a);
        @(negedge clk); io = b; cle = c; ale = a; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);
        bus_cycle(b, 1'b1, 1'b0);
    endtask

    task automatic clear_last();
        @(negedge clk); #1; last_op = -1;
    endtask

    task automatic check_last(input int exp, input string req);
        @(negedge clk); #1;
        checks++;
        if (last_op != exp) begin
            failures++;
            $display("FAIL %s: last op actual %0d expected %0d", req, last_op, exp);
        end
    endtask

    task automatic check_area(input int exp, input string req);
        @(negedge clk); #1;
        checks++;
        if (read_area !== exp[1:0]) begin
            failures++;
            $display("FAIL %s: read_area actual %0d expected %0d", req, read_area, exp);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_area(0, "R1");

        cur_req = "R1";
        clear_last(); bus_cycle(8'h90, 1'b0, 1'b0); check_last(-1, "R1");
        clear_last(); bus_cycle(8'h90, 1'b1, 1'b1); check_last(-1, "R1");

        cur_req = "R3";
        clear_last(); cmd(8'h90); check_last(2, "R3");
        clear_last(); cmd(8'h70); check_last(3, "R3");

        cur_req = "R2";
        cmd(8'h01); check_area(1, "R2");
        cmd(8'h50); check_area(2, "R2");
        clear_last(); cmd(8'h00); check_last(1, "R2"); check_area(0, "R2");

        cur_req = "R4";
        clear_last(); cmd(8'h80); check_last(-1, "R4");
        bus_cycle(8'h12, 1'b0, 1'b1); bus_cycle(8'h34, 1'b0, 1'b1);
        bus_cycle(8'h10, 1'b0, 1'b0);
        cur_req = "R10";
        bus_cycle(8'hD0, 1'b0, 1'b0);
        cur_req = "R4";
        cmd(8'h10); check_last(4, "R4");

        cur_req = "R5";
        cmd(8'h00); bus_cycle(8'h01, 1'b0, 1'b1); cmd(8'h8A);
        clear_last(); bus_cycle(8'h02, 1'b0, 1'b1); cmd(8'h10); check_last(6, "R5");

        cur_req = "R6";
        clear_last(); cmd(8'h60); bus_cycle(8'h07, 1'b0, 1'b1); cmd(8'hD0); check_last(5, "R6");

        cur_req = "R7";
        cmd(8'h50); cmd(8'h80); clear_last(); cmd(8'hFF); check_last(7, "R7");
        check_area(0, "R7");
        clear_last(); cmd(8'h10); check_last(-1, "R7");

        cur_req = "R8";
        cmd(8'h01);
        @(negedge clk); busy = 1'b1;
        clear_last(); cmd(8'h50); check_last(-1, "R8"); check_area(1, "R8");
        clear_last(); cmd(8'h70); check_last(3, "R8");
        @(negedge clk); busy = 1'b0;
        cmd(8'h80);
        @(negedge clk); busy = 1'b1;
        clear_last(); cmd(8'h10); check_last(-1, "R8");
        @(negedge clk); busy = 1'b0;
        clear_last(); cmd(8'h10); check_last(4, "R8");
        @(negedge clk); busy = 1'b1;
        clear_last(); cmd(8'hFF); check_last(7, "R8");
        check_area(0, "R8");
        @(negedge clk); busy = 1'b0;

        cur_req = "R9";
        clear_last(); cmd(8'h10); check_last(-1, "R9");
        cmd(8'h60); clear_last(); cmd(8'h10); check_last(-1, "R9");
        cmd(8'hD0); check_last(-1, "R9");
        cmd(8'h80); cmd(8'h55); cmd(8'h10); check_last(-1, "R9");
        cmd(8'h8A); cmd(8'h10); check_last(-1, "R9");

        cur_req = "R11";
        cmd(8'h80); clear_last(); cmd(8'h70); check_last(3, "R11");
        cmd(8'h10); check_last(4, "R11");

        cur_req = "R12";
        cmd(8'h80); clear_last(); cmd(8'h60); cmd(8'hD0); check_last(5, "R12");
        cmd(8'h00); cmd(8'h01); check_area(1, "R12");
        clear_last(); cmd(8'h8A); cmd(8'h10); check_last(-1, "R12");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule